// File: doc/BRIEF.md
# Auxiliary TAP Sharing Selector

This block sits next to the main JTAG test controller and decides who owns the JTAG pins. In the idle state the main controller owns them. The pin TDO then carries the main controller's TDO, and every auxiliary test port is parked with TMS high, so each one stays in its reset state.

The main controller decodes its instruction register and exposes the current instruction. When that instruction is one of four access opcodes and the main controller passes through Update-IR, the selector takes ownership on the falling edge of TCK. In single mode it connects pin TMS, TDI and TDO to one of three auxiliary ports: a debug port controller and two core debug controllers. In chain mode it connects the two core controllers in series, so that shifted bits pass through both.

While an auxiliary port owns the pins, the selector raises a hold output that freezes the main controller's state machine. Ownership is sticky. Only an assertion of the active-low reset, which stands for power-on reset or loss of the test-enable input, returns the pins to the main controller.

Top module: `tap_share_sel`

## Requirements
- R1: After `rst_ni` is low, and while no auxiliary port owns the pins, `tdo_o` equals `main_tdo_i` and `main_hold_o` is 0.
- R2: The access opcodes are 5'h11 for the debug port (aux index 0), 5'h12 for core A (index 1), 5'h13 for core B (index 2) and 5'h14 for the chain of core A followed by core B.
- R3: Ownership is taken only on a falling TCK edge at which `update_ir_i` is 1 and `ir_i` holds an access opcode. Any other opcode, or an access opcode without `update_ir_i`, leaves the idle state unchanged.
- R4: With a single port k owning the pins, `aux_tms_o[k]` follows `tms_i`, `aux_tdi_o[k]` follows `tdi_i`, and `tdo_o` follows `aux_tdo_i[k]`.
- R5: Every aux port that is not selected has `aux_tms_o` and `aux_tdi_o` held at 1.
- R6: In chain mode, `aux_tms_o[1]` and `aux_tms_o[2]` follow `tms_i`, `aux_tdi_o[1]` follows `tdi_i`, `aux_tdi_o[2]` follows `aux_tdo_i[1]`, and `tdo_o` follows `aux_tdo_i[2]`. A bit therefore crosses both cores with the sum of their shift lengths as latency.
- R7: `main_hold_o` is 1 exactly while an auxiliary port owns the pins.
- R8: Once ownership is taken, later Update-IR pulses with any opcode are ignored until reset.
- R9: Driving `rst_ni` low returns the selector to idle at once, without a TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on or test disable) |
| tms_i | input | 1 | Pin TMS |
| tdi_i | input | 1 | Pin TDI |
| tdo_o | output | 1 | Pin TDO |
| ir_i | input | 5 | Current instruction from the main controller |
| update_ir_i | input | 1 | Main controller is in Update-IR |
| main_tdo_i | input | 1 | TDO of the main controller |
| main_hold_o | output | 1 | Freezes the main controller's state machine |
| aux_tms_o | output | 3 | TMS to each auxiliary port |
| aux_tdi_o | output | 3 | TDI to each auxiliary port |
| aux_tdo_i | input | 3 | TDO from each auxiliary port |

## Verification
Ownership changes at the falling TCK edge that sees `update_ir_i`. Before the following rising edge, the routing outputs already reflect the new owner. The bench model therefore updates its owner at each falling edge and compares every routed output two time units later, still within the low phase.

Routing itself is purely combinational. Pin and auxiliary values are compared in that same half cycle, and the reset checks sample one time unit after `rst_ni` falls, with no clock edge in between. In chain mode, a bit captured at a rising edge must reach the pin after the two stub lengths added together, counted in rising edges. A queue of captured TDI bits is checked against the pin at that exact offset.

// File: rtl/tap_share_pkg.sv
package tap_share_pkg;
  localparam int IR_W_DEF  = 5;
  localparam int N_AUX_DEF = 3;

  localparam logic [IR_W_DEF-1:0] OP_DBG_DEF   = 5'h11;
  localparam logic [IR_W_DEF-1:0] OP_CORE_A_DEF = 5'h12;
  localparam logic [IR_W_DEF-1:0] OP_CORE_B_DEF = 5'h13;
  localparam logic [IR_W_DEF-1:0] OP_CHAIN_DEF = 5'h14;

  typedef enum logic [1:0] {
    OWN_IDLE   = 2'd0,
    OWN_SINGLE = 2'd1,
    OWN_CHAIN  = 2'd2
  } own_mode_e;
endpackage

// File: rtl/tap_share_decode.sv
module tap_share_decode #(
  parameter int IR_W    = 5,
  parameter int N_AUX   = 3,
  parameter logic [N_AUX*IR_W-1:0] OP_SINGLE = '0,
  parameter logic [IR_W-1:0] OP_CHAIN = '0,
  parameter int CHAIN_A = 1,
  parameter int CHAIN_B = 2
) (
  input  logic [IR_W-1:0]  ir_i,
  output logic [N_AUX-1:0] sel_o,
  output tap_share_pkg::own_mode_e mode_o
);
  logic [N_AUX-1:0] hit_single;
  logic             hit_chain;

  for (genvar k = 0; k < N_AUX; k++) begin : g_hit
    assign hit_single[k] = (ir_i == OP_SINGLE[k*IR_W +: IR_W]);
  end

  assign hit_chain = (ir_i == OP_CHAIN);

  always_comb begin
    sel_o  = '0;
    mode_o = tap_share_pkg::OWN_IDLE;
    if (hit_chain) begin
      sel_o[CHAIN_A] = 1'b1;
      sel_o[CHAIN_B] = 1'b1;
      mode_o = tap_share_pkg::OWN_CHAIN;
    end else if (|hit_single) begin
      sel_o  = hit_single;
      mode_o = tap_share_pkg::OWN_SINGLE;
    end
  end
endmodule

// File: rtl/tap_share_owner.sv
module tap_share_owner #(
  parameter int N_AUX = 3
) (
  input  logic                     tck_i,
  input  logic                     rst_ni,
  input  logic                     update_ir_i,
  input  logic [N_AUX-1:0]         dec_sel_i,
  input  tap_share_pkg::own_mode_e dec_mode_i,
  output logic [N_AUX-1:0]         sel_o,
  output tap_share_pkg::own_mode_e mode_o
);
  logic take;

  // sticky: only reset releases ownership
  assign take = update_ir_i && (mode_o == tap_share_pkg::OWN_IDLE) &&
                (dec_mode_i != tap_share_pkg::OWN_IDLE);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      mode_o <= tap_share_pkg::OWN_IDLE;
    end else if (take) begin
      sel_o  <= dec_sel_i;
      mode_o <= dec_mode_i;
    end
  end
endmodule

// File: rtl/tap_share_route.sv
module tap_share_route #(
  parameter int N_AUX   = 3,
  parameter int CHAIN_A = 1,
  parameter int CHAIN_B = 2
) (
  input  logic                     tms_i,
  input  logic                     tdi_i,
  input  logic                     main_tdo_i,
  input  logic [N_AUX-1:0]         sel_i,
  input  tap_share_pkg::own_mode_e mode_i,
  input  logic [N_AUX-1:0]         aux_tdo_i,
  output logic [N_AUX-1:0]         aux_tms_o,
  output logic [N_AUX-1:0]         aux_tdi_o,
  output logic                     tdo_o,
  output logic                     hold_o
);
  logic chain;
  assign chain = (mode_i == tap_share_pkg::OWN_CHAIN);

  for (genvar k = 0; k < N_AUX; k++) begin : g_lane
    if (k == CHAIN_B) begin : g_tail
      assign aux_tdi_o[k] = !sel_i[k] ? 1'b1 :
                            chain     ? aux_tdo_i[CHAIN_A] : tdi_i;
    end else begin : g_plain
      assign aux_tdi_o[k] = sel_i[k] ? tdi_i : 1'b1;
    end
    // parked ports see TMS high and stay in reset
    assign aux_tms_o[k] = sel_i[k] ? tms_i : 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      tap_share_pkg::OWN_CHAIN:  tdo_o = aux_tdo_i[CHAIN_B];
      tap_share_pkg::OWN_SINGLE: tdo_o = |(aux_tdo_i & sel_i);
      default:                   tdo_o = main_tdo_i;
    endcase
  end

  assign hold_o = (mode_i != tap_share_pkg::OWN_IDLE);
endmodule

// File: rtl/tap_share_sel.sv
module tap_share_sel #(
  parameter int IR_W    = tap_share_pkg::IR_W_DEF,
  parameter int N_AUX   = tap_share_pkg::N_AUX_DEF,
  parameter logic [IR_W-1:0] OP_DBG    = tap_share_pkg::OP_DBG_DEF,
  parameter logic [IR_W-1:0] OP_CORE_A = tap_share_pkg::OP_CORE_A_DEF,
  parameter logic [IR_W-1:0] OP_CORE_B = tap_share_pkg::OP_CORE_B_DEF,
  parameter logic [IR_W-1:0] OP_CHAIN  = tap_share_pkg::OP_CHAIN_DEF,
  parameter int CHAIN_A = 1,
  parameter int CHAIN_B = 2
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [IR_W-1:0]  ir_i,
  input  logic             update_ir_i,
  input  logic             main_tdo_i,
  output logic             main_hold_o,
  output logic [N_AUX-1:0] aux_tms_o,
  output logic [N_AUX-1:0] aux_tdi_o,
  input  logic [N_AUX-1:0] aux_tdo_i
);
  localparam logic [N_AUX*IR_W-1:0] OP_SINGLE = {OP_CORE_B, OP_CORE_A, OP_DBG};

  logic [N_AUX-1:0]         dec_sel, own_sel;
  tap_share_pkg::own_mode_e dec_mode, own_mode;

  tap_share_decode #(
    .IR_W(IR_W), .N_AUX(N_AUX), .OP_SINGLE(OP_SINGLE), .OP_CHAIN(OP_CHAIN),
    .CHAIN_A(CHAIN_A), .CHAIN_B(CHAIN_B)
  ) u_decode (
    .ir_i  (ir_i),
    .sel_o (dec_sel),
    .mode_o(dec_mode)
  );

  tap_share_owner #(.N_AUX(N_AUX)) u_owner (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .update_ir_i(update_ir_i),
    .dec_sel_i  (dec_sel),
    .dec_mode_i (dec_mode),
    .sel_o      (own_sel),
    .mode_o     (own_mode)
  );

  tap_share_route #(.N_AUX(N_AUX), .CHAIN_A(CHAIN_A), .CHAIN_B(CHAIN_B)) u_route (
    .tms_i     (tms_i),
    .tdi_i     (tdi_i),
    .main_tdo_i(main_tdo_i),
    .sel_i     (own_sel),
    .mode_i    (own_mode),
    .aux_tdo_i (aux_tdo_i),
    .aux_tms_o (aux_tms_o),
    .aux_tdi_o (aux_tdi_o),
    .tdo_o     (tdo_o),
    .hold_o    (main_hold_o)
  );
endmodule

// File: rtl/tap_share_sel_chk.sv
module tap_share_sel_chk #(
  parameter int IR_W    = 5,
  parameter int N_AUX   = 3,
  parameter logic [IR_W-1:0] OP_DBG   = '0,
  parameter logic [IR_W-1:0] OP_CHAIN = '0,
  parameter int CHAIN_A = 1,
  parameter int CHAIN_B = 2
) (
  input logic             tck_i,
  input logic             rst_ni,
  input logic             tdo_o,
  input logic [IR_W-1:0]  ir_i,
  input logic             update_ir_i,
  input logic             main_tdo_i,
  input logic             main_hold_o,
  input logic [N_AUX-1:0] aux_tms_o,
  input logic [N_AUX-1:0] aux_tdi_o,
  input logic [N_AUX-1:0] aux_tdo_i
);
  logic chain_seen;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) chain_seen <= 1'b0;
    else if (!main_hold_o && update_ir_i && ir_i == OP_CHAIN) chain_seen <= 1'b1;
  end

  assert_idle_tdo_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !main_hold_o |-> tdo_o == main_tdo_i);

  assert_idle_park_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !main_hold_o |-> (aux_tms_o == '1 && aux_tdi_o == '1));

  assert_single_lane_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !chain_seen |-> $onehot0(~aux_tms_o));

  assert_take_R3: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!main_hold_o && update_ir_i && ir_i == OP_DBG) |=> main_hold_o);

  assert_sticky_R8: assert property (@(negedge tck_i) disable iff (!rst_ni)
    main_hold_o |=> main_hold_o);

  assert_chain_link_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    chain_seen |-> (aux_tdi_o[CHAIN_B] == aux_tdo_i[CHAIN_A] && tdo_o == aux_tdo_i[CHAIN_B]));
endmodule

bind tap_share_sel tap_share_sel_chk #(
  .IR_W(IR_W), .N_AUX(N_AUX), .OP_DBG(OP_DBG), .OP_CHAIN(OP_CHAIN),
  .CHAIN_A(CHAIN_A), .CHAIN_B(CHAIN_B)
) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tdo_o(tdo_o), .ir_i(ir_i),
  .update_ir_i(update_ir_i), .main_tdo_i(main_tdo_i), .main_hold_o(main_hold_o),
  .aux_tms_o(aux_tms_o), .aux_tdi_o(aux_tdi_o), .aux_tdo_i(aux_tdo_i)
);

// File: tb/tap_share_sel_tb_top.sv
module aux_stub #(parameter int LEN = 3) (
  input  logic clk,
  input  logic rst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo
);
  logic [LEN-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (!tms) sr <= {tdi, sr[LEN-1:1]};
  end
  assign tdo = sr[0];
endmodule

module tap_share_sel_tb_top;
  localparam int L0 = 3, L1 = 4, L2 = 5;

  logic       tck = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tms = 1'b1, tdi = 1'b0, main_tdo = 1'b0, upd = 1'b0;
  logic [4:0] ir = 5'h01;
  logic       tdo, hold;
  logic [2:0] a_tms, a_tdi, a_tdo;

  int n_cmp = 0, n_bad = 0;
  int owner = -1;
  bit q[$];
  bit chain_track = 0;

  always #5 tck = ~tck;

  tap_share_sel dut_i (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo),
    .ir_i(ir), .update_ir_i(upd), .main_tdo_i(main_tdo), .main_hold_o(hold),
    .aux_tms_o(a_tms), .aux_tdi_o(a_tdi), .aux_tdo_i(a_tdo)
  );

  aux_stub #(L0) s0 (.clk(tck), .rst_n(rst_ni), .tms(a_tms[0]), .tdi(a_tdi[0]), .tdo(a_tdo[0]));
  aux_stub #(L1) s1 (.clk(tck), .rst_n(rst_ni), .tms(a_tms[1]), .tdi(a_tdi[1]), .tdo(a_tdo[1]));
  aux_stub #(L2) s2 (.clk(tck), .rst_n(rst_ni), .tms(a_tms[2]), .tdi(a_tdi[2]), .tdo(a_tdo[2]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int decode(input logic [4:0] op);
    case (op)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h14: return 3;
      default: return -1;
    endcase
  endfunction

  // reference model, updated at each falling edge, compared in the low phase
  always @(negedge tck) begin
    logic [2:0] e_tms, e_tdi;
    logic       e_tdo;
    if (!rst_ni) owner = -1;
    else if (owner == -1 && upd) owner = decode(ir);
    #2;
    e_tms = 3'b111; e_tdi = 3'b111; e_tdo = main_tdo;
    case (owner)
      0, 1, 2: begin
        e_tms[owner] = tms; e_tdi[owner] = tdi; e_tdo = a_tdo[owner];
      end
      3: begin
        e_tms[1] = tms; e_tms[2] = tms;
        e_tdi[1] = tdi; e_tdi[2] = a_tdo[1]; e_tdo = a_tdo[2];
      end
      default: ;
    endcase
    if (rst_ni) begin
      chk(tdo === e_tdo, owner == -1 ? "R1" : (owner == 3 ? "R6" : "R4"), tdo, e_tdo);
      chk(a_tms === e_tms, owner == 3 ? "R6" : "R5", a_tms, e_tms);
      chk(a_tdi === e_tdi, owner == 3 ? "R6" : "R5", a_tdi, e_tdi);
      chk(hold === (owner != -1), "R7", hold, owner != -1);
      if (chain_track && q.size() >= L1 + L2) begin
        chk(tdo === q[q.size() - L1 - L2], "R6", tdo, q[q.size() - L1 - L2]);
        void'(q.pop_front());
      end
    end
  end

  always @(posedge tck) if (chain_track) q.push_back(tdi);

  task automatic step(input logic t, input logic d);
    @(posedge tck); #1;
    tms = t; tdi = d; main_tdo = 1'($urandom_range(0, 1));
  endtask

  task automatic load(input logic [4:0] op, input logic u);
    @(posedge tck); #1;
    ir = op; upd = u;
    @(posedge tck); #1;
    upd = 1'b0; ir = 5'h01;
  endtask

  task automatic do_reset();
    @(posedge tck); #3;
    rst_ni = 1'b0;
    #1;
    chk(hold === 1'b0, "R9", hold, 0);
    chk(a_tms === 3'b111, "R9", a_tms, 3'b111);
    chk(tdo === main_tdo, "R9", tdo, main_tdo);
    @(posedge tck); #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge tck);
    #1 rst_ni = 1'b1;
    chk(hold === 1'b0, "R1", hold, 0);
    for (int i = 0; i < 6; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    load(5'h01, 1'b1);
    chk(hold === 1'b0, "R3", hold, 0);
    load(5'h11, 1'b0);
    chk(hold === 1'b0, "R3", hold, 0);

    load(5'h11, 1'b1);
    chk(hold === 1'b1 && a_tms[2:1] === 2'b11, "R2", {hold, a_tms}, 4'b1110);
    for (int i = 0; i < 12; i++) step(1'b0, 1'($urandom_range(0, 1)));
    load(5'h12, 1'b1);
    #3 chk(a_tms[1] === 1'b1 && a_tdi[1] === 1'b1, "R8", {a_tms[1], a_tdi[1]}, 2'b11);
    for (int i = 0; i < 4; i++) step(1'b0, 1'($urandom_range(0, 1)));
    do_reset();
    step(1'b1, 1'b0);

    load(5'h12, 1'b1);
    chk(hold === 1'b1 && a_tms[0] === 1'b1, "R2", {hold, a_tms[0]}, 2'b11);
    for (int i = 0; i < 10; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    do_reset();

    load(5'h13, 1'b1);
    chk(hold === 1'b1, "R2", hold, 1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'($urandom_range(0, 1)));
    load(5'h14, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'($urandom_range(0, 1)));
    do_reset();

    load(5'h14, 1'b1);
    chk(hold === 1'b1, "R2", hold, 1);
    step(1'b0, 1'b0);
    chain_track = 1;
    for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom_range(0, 1)));
    chain_track = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    do_reset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule